// File: doc/BRIEF.md
# Reference Clock Period and Frequency Monitor

This block watches one asynchronous reference clock from a faster local sampling clock and judges it in two independent ways. The reference passes through a two-flop synchronizer, and its rising edges are marked in the sampling domain. A period checker measures the spacing of every pair of consecutive rising edges, in sampling cycles. It flags a failure when that spacing falls outside half to one-and-a-half times a configured nominal. It also flags a missing edge as soon as the allowed span has run out, without waiting for the next edge.

A coarse frequency checker counts rising edges over a fixed window of sampling cycles. The window is a parameter, about 30 us by default. At each window close the checker compares the count with a configured nominal count and flags a deviation larger than 1/32 of that nominal, roughly 3%. Each check drives its own fail flag, and both checks feed one failure strobe that a downstream qualification accumulator can integrate.

Top module: `refmon_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release, `per_fail_o`, `freq_fail_o` and `fail_evt_o` are all 0.
- R2: A reference rising edge first sampled high at sampling edge e is counted at sampling edge e+2. A period is the number of sampling cycles between two counted edges.
- R3: A counted edge whose period is below `nom_period - floor(nom_period/2)` or above `nom_period + floor(nom_period/2)` is a period failure. A period equal to either limit passes.
- R4: When `nom_period + floor(nom_period/2)` cycles have elapsed since the last counted edge (or the last missing-edge failure) and no edge is counted in that cycle, a missing-edge failure is raised in that cycle. The check then re-arms, so it repeats every such span while the reference stays silent.
- R5: The first counted edge after reset, and the first counted edge after a missing-edge failure, start a new measurement and are never judged.
- R6: Every `WIN_CYC` sampling cycles the counted edges of the window just ended are compared with `nom_count`. `freq_fail_o` is loaded with 1 when the count exceeds `nom_count + floor(nom_count/32)` or falls below `nom_count - floor(nom_count/32)`, and with 0 otherwise. It holds that value until the next window close.
- R7: `per_fail_o` goes high with any period or missing-edge failure and stays high until a window close. At a window close it takes the failure status of that closing cycle alone.
- R8: `fail_evt_o` is high for exactly those cycles that follow a cycle with a period failure, a missing-edge failure or a coarse failure. A period failure and a coarse failure in the same cycle give a single one-cycle pulse.
- R9: The first window closes in the `WIN_CYC`-th cycle after reset release. Windows then follow back to back with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, asynchronous to `clk` |
| nom_period | input | PER_W | Nominal reference period in sampling cycles (held static) |
| nom_count | input | CNT_W | Nominal rising-edge count per window (held static) |
| per_fail_o | output | 1 | Period or missing-edge failure seen in the current window |
| freq_fail_o | output | 1 | Coarse frequency verdict of the last completed window |
| fail_evt_o | output | 1 | One-cycle strobe per failing cycle of either check |

## Verification
A window close and a period or missing-edge failure can fall in the same cycle. In that cycle the strobe must stay a single pulse, and the period flag must reload with the coincident failure rather than clear. One directed case provokes this on purpose. The reference stays silent from reset, and the nominal period is chosen so that its missing-edge span equals the window length. The first missing-edge failure and the first window verdict then land in the same cycle, and every later one does the same. Random streams of good, short and long periods across many windows also provoke chance coincidences. A timestamp-based model in the bench judges every cycle and compares all three outputs.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

  // Lower acceptance limit of a period: nominal minus half of it (floor).
  function automatic int unsigned per_lo_lim(input int unsigned nom);
    return nom - (nom >> 1);
  endfunction

  // Upper acceptance limit of a period: nominal plus half of it (floor).
  function automatic int unsigned per_hi_lim(input int unsigned nom);
    return nom + (nom >> 1);
  endfunction

  // Coarse tolerance as a right shift of the nominal count.
  function automatic int unsigned coarse_tol(input int unsigned nom, input int unsigned sh);
    return nom >> sh;
  endfunction

  // True when meas lies outside [nom - tol, nom + tol].
  function automatic logic out_of_band(input int unsigned meas,
                                       input int unsigned nom,
                                       input int unsigned tol);
    return (meas > nom + tol) || (meas + tol < nom);
  endfunction

  typedef struct packed {
    logic per;
    logic freq;
  } fail_pair_t;

endpackage

// File: rtl/refmon_sync.sv
module refmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_async,
  output logic rise
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its one-cycle-old copy
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], ref_async};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];

  // R2
  rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/refmon_period.sv
module refmon_period
  import refmon_pkg::*;
#(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic [PER_W-1:0] nom,
  output logic             per_evt
);
  localparam int CW = PER_W + 1;

  logic [CW-1:0] cnt, lo, hi;
  logic          armed;
  logic          too_short, too_long, timeout;

  assign lo = CW'(per_lo_lim(32'(nom)));
  assign hi = CW'(per_hi_lim(32'(nom)));

  assign too_short = cnt < lo;
  assign too_long  = cnt > hi;
  assign timeout   = !rise && (cnt >= hi);

  always_comb begin
    if (rise) per_evt = armed && (too_short || too_long);
    else      per_evt = timeout;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= CW'(1);
      armed <= 1'b0;
    end else if (rise) begin
      cnt   <= CW'(1);
      armed <= 1'b1;
    end else if (timeout) begin
      cnt   <= CW'(1);
      armed <= 1'b0;
    end else begin
      cnt   <= cnt + CW'(1);
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(nom) && nom >= PER_W'(2)) |-> (cnt <= hi));

  // R5
  unarmed_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !armed) |-> !per_evt);

endmodule

// File: rtl/refmon_window.sv
module refmon_window
  import refmon_pkg::*;
#(
  parameter int WIN_CYC = 7500,
  parameter int CNT_W   = 13,
  parameter int TOL_SH  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic [CNT_W-1:0] nom_count,
  output logic             tick,
  output logic             freq_evt
);
  localparam int WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;

  logic [WW-1:0]    wcnt;
  logic [CNT_W-1:0] ecnt;
  logic [CNT_W:0]   meas;

  assign tick = (wcnt == WW'(WIN_CYC - 1));
  assign meas = {1'b0, ecnt} + {{CNT_W{1'b0}}, rise};

  assign freq_evt = tick && out_of_band(32'(meas), 32'(nom_count),
                                        coarse_tol(32'(nom_count), TOL_SH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
      ecnt <= '0;
    end else begin
      wcnt <= tick ? '0 : wcnt + WW'(1);
      if (tick)          ecnt <= '0;
      else if (meas[CNT_W]) ecnt <= '1;
      else               ecnt <= meas[CNT_W-1:0];
    end
  end

  // R6
  ecnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ecnt) <= 32'(WIN_CYC));

  // R9
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && WIN_CYC > 1) |=> !tick);

endmodule

// File: rtl/refmon_top.sv
module refmon_top
  import refmon_pkg::*;
#(
  parameter int PER_W       = 16,
  parameter int WIN_CYC     = 7500,
  parameter int CNT_W       = 13,
  parameter int TOL_SH      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic [PER_W-1:0] nom_period,
  input  logic [CNT_W-1:0] nom_count,
  output logic             per_fail_o,
  output logic             freq_fail_o,
  output logic             fail_evt_o
);
  logic       rise;
  logic       tick;
  fail_pair_t evt;

  refmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ref_async(ref_in), .rise(rise)
  );

  refmon_period #(.PER_W(PER_W)) u_period (
    .clk(clk), .rst_n(rst_n), .rise(rise), .nom(nom_period), .per_evt(evt.per)
  );

  refmon_window #(.WIN_CYC(WIN_CYC), .CNT_W(CNT_W), .TOL_SH(TOL_SH)) u_window (
    .clk(clk), .rst_n(rst_n), .rise(rise), .nom_count(nom_count),
    .tick(tick), .freq_evt(evt.freq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_fail_o  <= 1'b0;
      freq_fail_o <= 1'b0;
      fail_evt_o  <= 1'b0;
    end else begin
      fail_evt_o <= evt.per | evt.freq;
      per_fail_o <= tick ? evt.per : (per_fail_o | evt.per);
      if (tick) freq_fail_o <= evt.freq;
    end
  end

  // R6
  ff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_fail_o) |-> $past(tick));

  // R6
  ff_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freq_fail_o) |-> fail_evt_o);

  // R7
  pf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(per_fail_o) |-> fail_evt_o);

  // R8
  evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_evt_o && !freq_fail_o) |-> per_fail_o);

endmodule

// File: tb/test_refmon_top.sv
module test_refmon_top;
  localparam int PER_W = 16;
  localparam int WIN   = 400;
  localparam int CNT_W = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic [PER_W-1:0] nom_period = PER_W'(20);
  logic [CNT_W-1:0] nom_count = CNT_W'(20);
  logic per_fail_o, freq_fail_o, fail_evt_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;
  string tag = "R1";

  always #2 clk = ~clk;

  refmon_top #(.PER_W(PER_W), .WIN_CYC(WIN), .CNT_W(CNT_W), .TOL_SH(5), .SYNC_STAGES(2))
  i_refmon_top (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .nom_period(nom_period),
    .nom_count(nom_count), .per_fail_o(per_fail_o), .freq_fail_o(freq_fail_o),
    .fail_evt_o(fail_evt_o)
  );

  // Timestamp-based model of the requirements
  bit h0, h1, h2;
  int cyc, lastr, ecnt_m;
  bit armed_m;
  bit e_evt, e_pf, e_ff;
  bit started = 1'b0;

  function automatic int lo_of(input int n); return (n + 1) / 2; endfunction
  function automatic int hi_of(input int n); return (3 * n) / 2; endfunction
  function automatic int tol_of(input int n); return n / 32; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      h0 = 0; h1 = 0; h2 = 0; cyc = 0; lastr = -1; armed_m = 0; ecnt_m = 0;
      e_evt = 0; e_pf = 0; e_ff = 0;
    end else begin
      bit rise_m, pe, fe, tk;
      int age, meas, nc, np;
      np = int'(nom_period);
      nc = int'(nom_count);
      rise_m = h1 && !h2;
      age = cyc - lastr;
      pe = 0;
      if (rise_m) begin
        pe = armed_m && (age < lo_of(np) || age > hi_of(np));
        lastr = cyc; armed_m = 1;
      end else if (age >= hi_of(np)) begin
        pe = 1; lastr = cyc; armed_m = 0;
      end
      tk = (cyc % WIN) == WIN - 1;
      meas = ecnt_m + (rise_m ? 1 : 0);
      fe = tk && (meas > nc + tol_of(nc) || meas + tol_of(nc) < nc);
      ecnt_m = tk ? 0 : meas;
      e_evt = pe || fe;
      e_pf = tk ? pe : (e_pf || pe);
      if (tk) e_ff = fe;
      h2 = h1; h1 = h0; h0 = ref_in;
      cyc++;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (started && rst_n) begin
      checks++;
      if (fail_evt_o !== e_evt || per_fail_o !== e_pf || freq_fail_o !== e_ff) begin
        fails++;
        if (fail_evt_o !== e_evt)
          $display("FAIL R8 [%s] cyc %0d fail_evt_o=%0b expected %0b", tag, cyc, fail_evt_o, e_evt);
        if (per_fail_o !== e_pf)
          $display("FAIL R7 [%s] cyc %0d per_fail_o=%0b expected %0b", tag, cyc, per_fail_o, e_pf);
        if (freq_fail_o !== e_ff)
          $display("FAIL R6 [%s] cyc %0d freq_fail_o=%0b expected %0b", tag, cyc, freq_fail_o, e_ff);
      end
    end
  end

  task automatic do_reset(input int np, input int nc);
    @(negedge clk);
    started = 1'b0;
    rst_n = 1'b0;
    ref_in = 1'b0;
    nom_period = PER_W'(np);
    nom_count = CNT_W'(nc);
    repeat (3) @(negedge clk);
    checks++;
    if (per_fail_o !== 1'b0 || freq_fail_o !== 1'b0 || fail_evt_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs %0b%0b%0b expected 000", per_fail_o, freq_fail_o, fail_evt_o);
    end
    rst_n = 1'b1;
    started = 1'b1;
  endtask

  task automatic ref_period(input int p);
    for (int i = 0; i < p; i++) begin
      ref_in = (i < p / 2) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    ref_in = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    // R1 and nominal stream: exact periods, R2 R5 (first edge unjudged)
    tag = "R2 R5";
    do_reset(20, 20);
    for (int k = 0; k < 60; k++) ref_period(20);

    // R3 limits: 10 and 30 pass, 9 and 31 fail
    tag = "R3";
    do_reset(20, 20);
    ref_period(20); ref_period(20); ref_period(10); ref_period(30);
    ref_period(9); ref_period(20); ref_period(31); ref_period(20);
    for (int k = 0; k < 40; k++) ref_period(20);

    // R4 missing edges repeat while silent, then recovery edge is unjudged (R5)
    tag = "R4 R5";
    do_reset(16, 25);
    for (int k = 0; k < 10; k++) ref_period(16);
    idle(200);
    for (int k = 0; k < 60; k++) ref_period(16);

    // R9 coincidence: silent reference, missing span 400 equals window length
    tag = "R9 R8 R7";
    do_reset(267, 1);
    idle(1250);

    // R6 coarse verdicts near the tolerance: count 64 +/- 2 passes, beyond fails
    tag = "R6";
    do_reset(6, 64);
    for (int k = 0; k < 66; k++) ref_period(6);
    ref_period(6 + 4);
    for (int k = 0; k < 80; k++) ref_period(5);
    for (int k = 0; k < 80; k++) ref_period(7);

    // Random streams mixing good, short, long and silent spans
    tag = "R2 R3 R4 R6";
    for (int r = 0; r < 20; r++) begin
      int np, nc;
      np = 8 + int'($urandom_range(32));
      nc = WIN / np + int'($urandom_range(2)) - 1;
      do_reset(np, nc);
      for (int k = 0; k < 1200 / np; k++) begin
        int sel, p;
        sel = int'($urandom_range(9));
        if (sel < 6)      p = np + int'($urandom_range(np * 4 / 5)) - np * 2 / 5;
        else if (sel < 8) p = int'($urandom_range(np - np / 2 - 1, 2));
        else              p = np + np / 2 + 1 + int'($urandom_range(np));
        if (p < 2) p = 2;
        ref_period(p);
      end
    end

    done = 1'b1;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d, expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule